// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the microprogram counter of a microcoded stack-machine control unit. Each cycle it takes the next-address field and the three jump-control bits of the microinstruction now being executed, together with the opcode byte last fetched from memory. From these it forms the address of the next microinstruction and registers it. That registered counter addresses the control store.

The block has two ways to change the next address from its plain value:

- **Opcode dispatch.** The fetched opcode byte is OR-ed into the low address bits. If the main loop's dispatch microinstruction carries a next-address field of zero, an opcode such as 0x36 sends control straight to the microroutine at address 0x036.
- **Conditional branching.** A condition flag is OR-ed into the top address bit only. This gives a two-way branch between an address and the same address plus 256.

The negative and zero flags of the ALU are captured at the end of the cycle that produced them. A jump bit in the following microinstruction then tests them.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `mpc` loads `MAIN_ADDR` (default 0x000) and both latched flags clear. The first microinstruction after reset therefore sees N=0 and Z=0.
- R2: When `jmpc`, `jamn` and `jamz` are all low, the `mpc` value after the next clock edge equals `naddr` unchanged, whatever `mbr` and the flags hold.
- R3: When `jmpc` is high, bits 7..0 of the next `mpc` equal `naddr[7:0]` bitwise-OR `mbr`.
- R4: When `jamn` is high and the N flag latched at the previous edge is 1, bit 8 of the next `mpc` is 1.
- R5: When `jamz` is high and the Z flag latched at the previous edge is 1, bit 8 of the next `mpc` is 1.
- R6: The flags tested by `jamn`/`jamz` are the `alu_n`/`alu_z` values presented in the previous cycle, not the current cycle's values.
- R7: The jump bits never clear an address bit. When `jmpc` is low, `mbr` has no effect on bits 7..0. When neither condition fires, bit 8 equals `naddr[8]`.
- R8: A dispatch with `naddr`=0x000, `jmpc`=1 and `mbr`=0x36 yields `mpc`=0x036.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| naddr | input | 9 | Next-address field of the current microinstruction |
| jmpc | input | 1 | OR the opcode byte into the low address bits |
| jamn | input | 1 | OR the latched N flag into the top address bit |
| jamz | input | 1 | OR the latched Z flag into the top address bit |
| alu_n | input | 1 | Negative flag of this cycle's ALU result |
| alu_z | input | 1 | Zero flag of this cycle's ALU result |
| mbr | input | 8 | Fetched opcode byte |
| mpc | output | 9 | Registered microprogram counter |

## Verification
The bench builds the block with its defaults: a 9-bit counter, an 8-bit opcode byte and a main-loop address of zero. With these, every dispatch target and both halves of the branch space can be reached from random next-address fields and opcodes. The directed steps cover the zero-based opcode dispatch, a reset taken while the flag inputs are high, and flag sequences where the current and previous ALU flags differ. These are the cases that tell apart a flag used one cycle late from one used too early.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef struct packed {
    logic dispatch;
    logic on_neg;
    logic on_zero;
  } jump_ctl_t;

  typedef struct packed {
    logic neg;
    logic zero;
  } flag_pair_t;
endpackage

// File: rtl/mseq_flag_latch.sv
module mseq_flag_latch
  import mseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flag_pair_t flags_in,
  output flag_pair_t flags_q
);
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_in;
  end
endmodule

// File: rtl/mseq_low_merge.sv
module mseq_low_merge #(
  parameter int ADDR_W = 9,
  parameter int OPC_W  = 8
) (
  input  logic [ADDR_W-2:0] field_low,
  input  logic              dispatch,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-2:0] merged_low
);
  for (genvar i = 0; i < ADDR_W-1; i++) begin : g_bit
    if (i < OPC_W) begin : g_or
      assign merged_low[i] = field_low[i] | (dispatch & opcode[i]);
    end else begin : g_pass
      assign merged_low[i] = field_low[i];
    end
  end
endmodule

// File: rtl/mseq_high_merge.sv
module mseq_high_merge
  import mseq_pkg::*;
(
  input  logic       field_high,
  input  jump_ctl_t  ctl,
  input  flag_pair_t flags_q,
  output logic       merged_high
);
  logic neg_hit;
  logic zero_hit;

  always_comb begin
    neg_hit     = ctl.on_neg  & flags_q.neg;
    zero_hit    = ctl.on_zero & flags_q.zero;
    merged_high = field_high | neg_hit | zero_hit;
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int              ADDR_W    = 9,
  parameter int              OPC_W     = 8,
  parameter logic [ADDR_W-1:0] MAIN_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] naddr,
  input  logic              jmpc,
  input  logic              jamn,
  input  logic              jamz,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [OPC_W-1:0]  mbr,
  output logic [ADDR_W-1:0] mpc
);
  localparam int LOW_W = ADDR_W - 1;

  jump_ctl_t         ctl;
  flag_pair_t        flags_now;
  flag_pair_t        flags_q;
  logic [LOW_W-1:0]  low_next;
  logic              high_next;

  assign ctl       = '{dispatch: jmpc, on_neg: jamn, on_zero: jamz};
  assign flags_now = '{neg: alu_n, zero: alu_z};

  mseq_flag_latch u_flags (
    .clk      (clk),
    .rst      (rst),
    .flags_in (flags_now),
    .flags_q  (flags_q)
  );

  mseq_low_merge #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_low (
    .field_low  (naddr[LOW_W-1:0]),
    .dispatch   (ctl.dispatch),
    .opcode     (mbr),
    .merged_low (low_next)
  );

  mseq_high_merge u_high (
    .field_high  (naddr[ADDR_W-1]),
    .ctl         (ctl),
    .flags_q     (flags_q),
    .merged_high (high_next)
  );

  always_ff @(posedge clk) begin
    if (rst) mpc <= MAIN_ADDR;
    else     mpc <= {high_next, low_next};
  end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int                ADDR_W    = 9,
  parameter int                OPC_W     = 8,
  parameter logic [ADDR_W-1:0] MAIN_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] naddr,
  input logic              jmpc,
  input logic              jamn,
  input logic              jamz,
  input logic              alu_n,
  input logic              alu_z,
  input logic [OPC_W-1:0]  mbr,
  input logic [ADDR_W-1:0] mpc
);
  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> mpc == MAIN_ADDR); // R1
  AST_PLAIN_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!jmpc && !jamn && !jamz) |=> mpc == $past(naddr)); // R2
  AST_DISPATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    jmpc |=> mpc[OPC_W-1:0] == ($past(naddr[OPC_W-1:0]) | $past(mbr))); // R3
  AST_NEG_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (jamn && $past(!rst) && $past(alu_n)) |=> mpc[ADDR_W-1]); // R4
  AST_ZERO_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (jamz && $past(!rst) && $past(alu_z)) |=> mpc[ADDR_W-1]); // R5
  AST_NO_MBR_LEAK: assert property (@(posedge clk) disable iff (rst)
    !jmpc |=> mpc[OPC_W-1:0] == $past(naddr[OPC_W-1:0])); // R7
  AST_NO_FALSE_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (!jamn && !jamz) |=> mpc[ADDR_W-1] == $past(naddr[ADDR_W-1])); // R7
endmodule

bind mseq_top mseq_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAIN_ADDR(MAIN_ADDR)) u_chk (
  .clk(clk), .rst(rst), .naddr(naddr), .jmpc(jmpc), .jamn(jamn), .jamz(jamz),
  .alu_n(alu_n), .alu_z(alu_z), .mbr(mbr), .mpc(mpc)
);

// File: tb/mseq_top_bench.sv
module mseq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] naddr = '0;
  logic       jmpc = 1'b0, jamn = 1'b0, jamz = 1'b0;
  logic       alu_n = 1'b0, alu_z = 1'b0;
  logic [7:0] mbr = '0;
  logic [8:0] mpc;

  int checks = 0;
  int failures = 0;
  bit prev_n = 1'b0, prev_z = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mseq_top u_mseq_top (
    .clk(clk), .rst(rst), .naddr(naddr), .jmpc(jmpc), .jamn(jamn), .jamz(jamz),
    .alu_n(alu_n), .alu_z(alu_z), .mbr(mbr), .mpc(mpc)
  );

  function automatic logic [8:0] model(input logic [8:0] f, input bit jc, input bit jn,
                                       input bit jz, input bit fn, input bit fz,
                                       input logic [7:0] op);
    logic [8:0] r;
    r[7:0] = f[7:0] | (jc ? op : 8'h00);
    r[8]   = f[8] | (jn & fn) | (jz & fz);
    return r;
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] f, input bit jc, input bit jn, input bit jz,
                      input bit an, input bit az, input logic [7:0] op, input string tag);
    logic [8:0] exp;
    naddr = f; jmpc = jc; jamn = jn; jamz = jz; alu_n = an; alu_z = az; mbr = op;
    exp = model(f, jc, jn, jz, prev_n, prev_z, op);
    @(posedge clk);
    @(negedge clk);
    check(tag, mpc, exp);
    prev_n = an;
    prev_z = az;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset with flag inputs high
    alu_n = 1'b1; alu_z = 1'b1; naddr = 9'h1A5; jmpc = 1'b1; mbr = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset address", mpc, 9'h000);
    prev_n = 1'b0; prev_z = 1'b0;
    step(9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R1 flags cleared");
    // R8 dispatch of 0x36
    step(9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h36, "R8 dispatch 0x36");
    // R2 plain field with noisy mbr and flags
    step(9'h0C3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, "R2 plain field");
    step(9'h1FF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55, "R2 plain top set");
    // R3 OR merge of overlapping bits
    step(9'h10F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, "R3 or merge");
    // R4 and R6: flag from previous cycle
    step(9'h004, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R6 setup n");
    step(9'h004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R4 neg branch");
    step(9'h004, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R6 current n ignored");
    // R5
    step(9'h007, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R6 setup z");
    step(9'h007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5 zero branch");
    step(9'h007, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, "R6 current z ignored");
    // R7: jam bits with flags clear keep low bits and high bit
    step(9'h081, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, "R7 no leak");
    step(9'h081, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, "R7 no false branch");
    for (int i = 0; i < 400; i++) begin
      step(9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom), "R2 R3 R4 R5 R7 random");
    end
    // R1 again mid-run
    @(negedge clk);
    rst = 1'b1; alu_n = 1'b1; alu_z = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", mpc, 9'h000);
    prev_n = 1'b0; prev_z = 1'b0;
    step(9'h020, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R1 flags cleared again");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule